// File: doc/BRIEF.md
# Indirect SDRAM Command Port

This block gives a processor direct, command-by-command control of SDRAM through a single 16-bit register. A receive memory and a transmit memory each have their own register address and their own SDRAM pin set. The processor writes an access code, an address and a data word. The block turns the code into one SDRAM command cycle with the right chip-select, row strobe, column strobe and write-enable levels. It then keeps a busy flag high until the command's timing has run out. The block never schedules anything on its own. Refresh, row management and ordering are all left to the processor.

To read, the processor first issues a read command through the usual three-word sequence. It waits for busy to clear, then reads the same register address to get the word the SDRAM returned. The processor bus is a plain register port, not a stream: it has no back-pressure. Instead, any write that arrives while that memory's busy flag is high is dropped whole. The processor must poll busy before it starts a new sequence.

Top module: `sdcmd_bridge`

## Requirements
- R1: A processor write reaches the receive port only when the address is exactly 0x2000000 and the transmit port only when it is exactly 0x3000000. A write to any other address changes nothing, and commands on one port never show up on the other.
- R2: Every command takes three register writes:
  - Word one holds the access code in bits [15:12] and SDRAM address bits [12:8] in bits [4:0].
  - Word two holds SDRAM address bits [7:0] in bits [7:0].
  - Word three is the write data.
  - The command appears on the pins for exactly one cycle, in the cycle after the clock edge that accepted word three.
- R3: Pin levels as (cs_n, ras_n, cas_n, we_n), with the bank pin set as listed:
  - Code 0011 activates bank 0 and 0111 activates bank 1: 0011, bank 0/1.
  - Code 0001 reads bank 0 and 0101 reads bank 1: 0101, bank 0/1.
  - Code 0010 writes bank 0 and 0110 writes bank 1: 0100, bank 0/1.
  - Code 1001 is precharge: 0010, bank 0.
  - Code 1010 is auto refresh: 0001, bank 0.
  - Code 1100 is mode register load: 0000, bank 0.
  - Code 1110 is self refresh: 0001 with clock enable low, bank 0.
  - With no command, the pins sit at 1111.
- R4: Codes 0000, 0100, 1000, 1011, 1101 and 1111 produce no SDRAM command and leave busy low.
- R5: Busy goes high in the command cycle and stays high for a set number of cycles:
  - read: CAS latency + 1
  - activate: 3 (tRCD)
  - precharge: 3 (tRP)
  - auto refresh: 8 (tRFC)
  - write: 2
  - mode load: 2
  - self-refresh entry: 2
- R6: While busy is high, register writes to that port are ignored, including the words of a partial sequence. The next sequence after busy clears starts again at word one.
- R7: The read word is sampled from the SDRAM data input at the clock edge CAS-latency cycles after the edge at which the read command was on the pins. A processor read of the port's address returns that word. In every other cycle the readback bus is zero.
- R8: CAS latency is 3 after reset. A mode register load with address bits [6:4] = 2 sets it to 2, and with bits [6:4] = 3 sets it to 3. Other values leave it unchanged.
- R9: After self refresh, clock enable stays low and no command is issued through no-op or reserved codes. The next valid code first raises clock enable, waits 10 cycles with busy high, and only then issues that command.
- R10: The readback word holds its value until the next read command completes, whatever other commands run in between.
- R11: The data output enable is high only in the cycle a write command is on the pins, and the data output then carries word three.
- R12: During and right after reset, the pins are at 1111, clock enable is high, busy is low, output enable is low and readback is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 26 | Processor address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor readback data |
| busy | output | 2 | Per-port busy flag (0 receive, 1 transmit) |
| sd_cke | output | 2 | Per-port SDRAM clock enable |
| sd_cs_n | output | 2 | Per-port chip select, active low |
| sd_ras_n | output | 2 | Per-port row strobe, active low |
| sd_cas_n | output | 2 | Per-port column strobe, active low |
| sd_we_n | output | 2 | Per-port write enable, active low |
| sd_ba | output | 2 | Per-port bank select |
| sd_addr | output | 2x13 | Per-port SDRAM address |
| sd_dq_out | output | 2x16 | Per-port SDRAM write data |
| sd_dq_oe | output | 2 | Per-port data output enable |
| sd_dq_in | input | 2x16 | Per-port SDRAM read data |

## Verification
Most internal faults show up at the pins within one command:
- A wrong word counter shows up as an address taken from the wrong word, or as a stray command on the next sequence.
- A wrong timing counter changes the length of the busy pulse, which the bench counts cycle by cycle.
- A wrong CAS latency, or a capture at the wrong edge, returns a neighbouring word from a data input that changes every cycle.
- A lost self-refresh flag either issues a command a full exit time too early or leaves clock enable in the wrong state. Either is visible in the cycle the command appears.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t PIN_IDLE = 4'b1111;
  localparam pins_t PIN_ACT  = 4'b0011;
  localparam pins_t PIN_RD   = 4'b0101;
  localparam pins_t PIN_WR   = 4'b0100;
  localparam pins_t PIN_PRE  = 4'b0010;
  localparam pins_t PIN_REF  = 4'b0001;
  localparam pins_t PIN_MRS  = 4'b0000;

  typedef enum logic [2:0] {K_NONE, K_ACT, K_RD, K_WR, K_PRE, K_REF, K_MRS, K_SREF} kind_t;

  typedef struct packed {
    kind_t kind;
    logic  bank;
  } dec_t;

  function automatic dec_t decode_code(input logic [3:0] c);
    dec_t d;
    d.kind = K_NONE;
    d.bank = 1'b0;
    case (c)
      4'h1: d.kind = K_RD;
      4'h2: d.kind = K_WR;
      4'h3: d.kind = K_ACT;
      4'h5: begin d.kind = K_RD;  d.bank = 1'b1; end
      4'h6: begin d.kind = K_WR;  d.bank = 1'b1; end
      4'h7: begin d.kind = K_ACT; d.bank = 1'b1; end
      4'h9: d.kind = K_PRE;
      4'hA: d.kind = K_REF;
      4'hC: d.kind = K_MRS;
      4'hE: d.kind = K_SREF;
      default: d.kind = K_NONE;
    endcase
    return d;
  endfunction

  function automatic pins_t pins_of(input kind_t k);
    case (k)
      K_ACT:         return PIN_ACT;
      K_RD:          return PIN_RD;
      K_WR:          return PIN_WR;
      K_PRE:         return PIN_PRE;
      K_REF, K_SREF: return PIN_REF;
      K_MRS:         return PIN_MRS;
      default:       return PIN_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/sdcmd_collect.sv
`timescale 1ns/1ps
module sdcmd_collect #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              fire,
  output logic [3:0]        code,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  localparam int HI_W = ADDR_W - 8;

  logic [1:0]      word_q;
  logic [3:0]      code_q;
  logic [HI_W-1:0] hi_q;
  logic [7:0]      lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      code_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (wr_en) begin
      case (word_q)
        2'd0: begin
          code_q <= wdata[DATA_W-1 -: 4];
          hi_q   <= wdata[HI_W-1:0];
          word_q <= 2'd1;
        end
        2'd1: begin
          lo_q   <= wdata[7:0];
          word_q <= 2'd2;
        end
        default: word_q <= 2'd0;
      endcase
    end
  end

  assign fire = wr_en && (word_q == 2'd2);
  assign code = code_q;
  assign addr = {hi_q, lo_q};
  assign data = wdata;
endmodule

// File: rtl/sdcmd_seq.sv
`timescale 1ns/1ps
module sdcmd_seq import sdcmd_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int TRCD   = 3,
  parameter int TRP    = 3,
  parameter int TRFC   = 8,
  parameter int TWR    = 2,
  parameter int TMRD   = 2,
  parameter int TSRE   = 2,
  parameter int TXSR   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [3:0]        code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] dq_in,
  output logic              busy,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int CNT_W = $clog2(TRFC + TXSR + 8);

  typedef enum logic [1:0] {S_IDLE, S_EXIT, S_BUSY} st_t;

  st_t               st_q;
  logic [CNT_W-1:0]  cnt_q;
  pins_t             pins_q;
  logic [1:0]        cl_q;
  logic              in_sr_q, rd_pend_q;
  dec_t              fresh_d, pend_d, use_d;
  logic [ADDR_W-1:0] pend_addr, use_addr;
  logic [DATA_W-1:0] pend_data, use_data;
  logic              issue;

  function automatic logic [CNT_W-1:0] wait_of(input kind_t k, input logic [1:0] cl);
    case (k)
      K_RD:    return CNT_W'(cl) + CNT_W'(1);
      K_WR:    return CNT_W'(TWR);
      K_ACT:   return CNT_W'(TRCD);
      K_PRE:   return CNT_W'(TRP);
      K_REF:   return CNT_W'(TRFC);
      K_MRS:   return CNT_W'(TMRD);
      default: return CNT_W'(TSRE);
    endcase
  endfunction

  always_comb begin
    fresh_d  = decode_code(code);
    use_d    = (st_q == S_EXIT) ? pend_d    : fresh_d;
    use_addr = (st_q == S_EXIT) ? pend_addr : addr;
    use_data = (st_q == S_EXIT) ? pend_data : data;
    issue    = (st_q == S_IDLE && fire && fresh_d.kind != K_NONE && !in_sr_q) ||
               (st_q == S_EXIT && cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= '0;
      pins_q    <= PIN_IDLE;
      cl_q      <= 2'd3;
      in_sr_q   <= 1'b0;
      rd_pend_q <= 1'b0;
      cke       <= 1'b1;
      ba        <= 1'b0;
      sd_addr   <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rdata     <= '0;
      pend_d    <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else begin
      pins_q <= PIN_IDLE;
      dq_oe  <= 1'b0;
      if (issue) begin
        pins_q  <= pins_of(use_d.kind);
        ba      <= use_d.bank;
        sd_addr <= use_addr;
        cnt_q   <= wait_of(use_d.kind, cl_q);
        st_q    <= S_BUSY;
        if (use_d.kind == K_WR) begin
          dq_oe  <= 1'b1;
          dq_out <= use_data;
        end
        if (use_d.kind == K_RD) rd_pend_q <= 1'b1;
        if (use_d.kind == K_MRS) begin
          if (use_addr[6:4] == 3'd2) cl_q <= 2'd2;
          else if (use_addr[6:4] == 3'd3) cl_q <= 2'd3;
        end
        if (use_d.kind == K_SREF) begin
          cke     <= 1'b0;
          in_sr_q <= 1'b1;
        end
      end else begin
        case (st_q)
          S_IDLE: if (fire && fresh_d.kind != K_NONE) begin
            cke       <= 1'b1;
            in_sr_q   <= 1'b0;
            pend_d    <= fresh_d;
            pend_addr <= addr;
            pend_data <= data;
            cnt_q     <= CNT_W'(TXSR);
            st_q      <= S_EXIT;
          end
          S_EXIT: cnt_q <= cnt_q - CNT_W'(1);
          default: begin
            if (cnt_q == CNT_W'(1)) begin
              st_q <= S_IDLE;
              if (rd_pend_q) begin
                rdata     <= dq_in;
                rd_pend_q <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
        endcase
      end
    end
  end

  assign busy  = (st_q != S_IDLE);
  assign cs_n  = pins_q.cs_n;
  assign ras_n = pins_q.ras_n;
  assign cas_n = pins_q.cas_n;
  assign we_n  = pins_q.we_n;
endmodule

// File: rtl/sdcmd_bridge.sv
`timescale 1ns/1ps
module sdcmd_bridge import sdcmd_pkg::*; #(
  parameter int                CPU_AW  = 26,
  parameter logic [CPU_AW-1:0] RX_BASE = 26'h2000000,
  parameter logic [CPU_AW-1:0] TX_BASE = 26'h3000000,
  parameter int                ADDR_W  = 13,
  parameter int                DATA_W  = 16,
  parameter int                TRCD    = 3,
  parameter int                TRP     = 3,
  parameter int                TRFC    = 8,
  parameter int                TWR     = 2,
  parameter int                TMRD    = 2,
  parameter int                TSRE    = 2,
  parameter int                TXSR    = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CPU_AW-1:0]            cpu_addr,
  input  logic                         cpu_wr,
  input  logic                         cpu_rd,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic [1:0]                   busy,
  output logic [1:0]                   sd_cke,
  output logic [1:0]                   sd_cs_n,
  output logic [1:0]                   sd_ras_n,
  output logic [1:0]                   sd_cas_n,
  output logic [1:0]                   sd_we_n,
  output logic [1:0]                   sd_ba,
  output logic [1:0][ADDR_W-1:0]       sd_addr,
  output logic [1:0][DATA_W-1:0]       sd_dq_out,
  output logic [1:0]                   sd_dq_oe,
  input  logic [1:0][DATA_W-1:0]       sd_dq_in
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]             sel, wr_en, fire;
  logic [NPORT-1:0][3:0]        code;
  logic [NPORT-1:0][ADDR_W-1:0] c_addr;
  logic [NPORT-1:0][DATA_W-1:0] c_data, rd_word;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [CPU_AW-1:0] BASE = (p == 0) ? RX_BASE : TX_BASE;
    assign sel[p]   = (cpu_addr == BASE);
    assign wr_en[p] = cpu_wr && sel[p] && !busy[p];

    sdcmd_collect #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_collect (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[p]), .wdata(cpu_wdata),
      .fire(fire[p]), .code(code[p]), .addr(c_addr[p]), .data(c_data[p])
    );

    sdcmd_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRCD(TRCD), .TRP(TRP), .TRFC(TRFC),
      .TWR(TWR), .TMRD(TMRD), .TSRE(TSRE), .TXSR(TXSR)
    ) u_seq (
      .clk(clk), .rst_n(rst_n), .fire(fire[p]), .code(code[p]),
      .addr(c_addr[p]), .data(c_data[p]), .dq_in(sd_dq_in[p]),
      .busy(busy[p]), .cke(sd_cke[p]), .cs_n(sd_cs_n[p]), .ras_n(sd_ras_n[p]),
      .cas_n(sd_cas_n[p]), .we_n(sd_we_n[p]), .ba(sd_ba[p]), .sd_addr(sd_addr[p]),
      .dq_out(sd_dq_out[p]), .dq_oe(sd_dq_oe[p]), .rdata(rd_word[p])
    );
  end

  always_comb begin
    cpu_rdata = '0;
    for (int p = 0; p < NPORT; p++)
      if (cpu_rd && sel[p]) cpu_rdata = rd_word[p];
  end
endmodule

// File: rtl/sdcmd_chk.sv
`timescale 1ns/1ps
module sdcmd_chk #(
  parameter int NPORT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] busy,
  input logic [NPORT-1:0] sd_cke,
  input logic [NPORT-1:0] sd_cs_n,
  input logic [NPORT-1:0] sd_ras_n,
  input logic [NPORT-1:0] sd_cas_n,
  input logic [NPORT-1:0] sd_we_n,
  input logic [NPORT-1:0] sd_dq_oe
);
  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    // R11
    oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe[p] |-> ({sd_cs_n[p], sd_ras_n[p], sd_cas_n[p], sd_we_n[p]} == 4'b0100));
    // R2
    one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cs_n[p] |=> sd_cs_n[p]);
    // R5
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cs_n[p] |-> busy[p]);
    // R9
    sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sd_cke[p] && $past(!sd_cke[p])) |-> sd_cs_n[p]);
    // R4
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[p]) |-> (!sd_cs_n[p] || $rose(sd_cke[p])));
  end
endmodule

bind sdcmd_bridge sdcmd_chk #(.NPORT(2)) u_sdcmd_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
  .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dq_oe(sd_dq_oe)
);

// File: tb/test_sdcmd_bridge.sv
`timescale 1ns/1ps
module test_sdcmd_bridge;
  localparam int AW = 13, DW = 16;
  localparam int TRCD = 3, TRP = 3, TRFC = 8, TWR = 2, TMRD = 2, TSRE = 2, TXSR = 10;
  localparam logic [25:0] RXB = 26'h2000000, TXB = 26'h3000000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [25:0]          cpu_addr = '0;
  logic                 cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [DW-1:0]        cpu_wdata = '0;
  logic [DW-1:0]        cpu_rdata;
  logic [1:0]           busy, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dq_oe;
  logic [1:0][AW-1:0]   sd_addr;
  logic [1:0][DW-1:0]   sd_dq_out;
  logic [1:0][DW-1:0]   sd_dq_in = '0;

  sdcmd_bridge i_sdcmd_bridge (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0]    pins;
    logic          ba;
    logic [AW-1:0] addr;
    logic          oe;
    logic [DW-1:0] data;
    logic          cke;
    int            due;
    int            cl;
  } exp_t;

  exp_t q0[$], q1[$];
  logic [DW-1:0] exp_rd [2] = '{16'h0, 16'h0};
  int  seen [2] = '{0, 0};
  int  cl_m [2] = '{3, 3};
  bit  sr_m [2] = '{1'b0, 1'b0};

  function automatic logic [DW-1:0] pat(int p, int n);
    return DW'(n * 37) ^ ((p == 1) ? 16'hA5A5 : 16'h3C3C);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected commands as they appear on the pins
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      for (int p = 0; p < 2; p++) begin
        exp_t e;
        sd_dq_in[p] = pat(p, cyc);
        if (sd_dq_oe[p] && sd_cs_n[p]) chk("R11", 1, 0, "output enable without command");
        if (!sd_cs_n[p]) begin
          seen[p]++;
          if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
            chk("R4", 1, 0, "unexpected command");
          end else begin
            e = (p == 0) ? q0.pop_front() : q1.pop_front();
            chk("R3", {sd_cs_n[p], sd_ras_n[p], sd_cas_n[p], sd_we_n[p]}, e.pins, "pin levels");
            chk("R3", sd_ba[p], e.ba, "bank");
            chk("R2", sd_addr[p], e.addr, "address");
            chk("R2", cyc, e.due, "issue cycle");
            chk("R9", sd_cke[p], e.cke, "clock enable at command");
            chk("R11", sd_dq_oe[p], e.oe, "output enable");
            if (e.oe) chk("R11", sd_dq_out[p], e.data, "write data");
            if (e.pins == 4'b0101) exp_rd[p] = pat(p, cyc + e.cl);
          end
        end
      end
    end
  end

  task automatic word(logic [25:0] a, logic [DW-1:0] w);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = w; cpu_wr = 1'b1;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic words(logic [25:0] base, logic [3:0] code, logic [AW-1:0] a, logic [DW-1:0] d);
    word(base, {code, 7'd0, a[12:8]});
    word(base, {8'd0, a[7:0]});
    word(base, d);
  endtask

  task automatic model(input logic [3:0] code, input int cl, output bit v,
                       output logic [3:0] pins, output logic ba, output int wt);
    v = 1'b1; ba = 1'b0; pins = 4'b1111; wt = 0;
    case (code)
      4'h1, 4'h5: begin pins = 4'b0101; wt = cl + 1; end
      4'h2, 4'h6: begin pins = 4'b0100; wt = TWR;    end
      4'h3, 4'h7: begin pins = 4'b0011; wt = TRCD;   end
      4'h9: begin pins = 4'b0010; wt = TRP;  end
      4'hA: begin pins = 4'b0001; wt = TRFC; end
      4'hC: begin pins = 4'b0000; wt = TMRD; end
      4'hE: begin pins = 4'b0001; wt = TSRE; end
      default: v = 1'b0;
    endcase
    if (code inside {4'h5, 4'h6, 4'h7}) ba = 1'b1;
  endtask

  // driver: sends a sequence, pushes the expected command, measures busy
  task automatic issue(int p, logic [3:0] code, logic [AW-1:0] a, logic [DW-1:0] d,
                       string req, bit measure = 1'b1);
    bit v; logic [3:0] pins; logic ba; int wt, delay, n0, cnt;
    exp_t e;
    @(negedge clk);
    while (busy[p]) @(negedge clk);
    model(code, cl_m[p], v, pins, ba, wt);
    words((p == 1) ? TXB : RXB, code, a, d);
    n0 = cyc + 1;
    delay = (v && sr_m[p]) ? TXSR : 0;
    if (v) begin
      e.pins = pins; e.ba = ba; e.addr = a; e.oe = (pins == 4'b0100); e.data = d;
      e.cke = (code != 4'hE); e.due = n0 + delay; e.cl = cl_m[p];
      if (p == 0) q0.push_back(e); else q1.push_back(e);
      if (code == 4'hC && a[6:4] == 3'd2) cl_m[p] = 2;
      if (code == 4'hC && a[6:4] == 3'd3) cl_m[p] = 3;
      sr_m[p] = (code == 4'hE);
    end
    if (measure) begin
      cnt = 0;
      @(negedge clk);
      while (busy[p]) begin cnt++; @(negedge clk); end
      chk(req, cnt, v ? delay + wt : 0, "busy cycles");
    end
  endtask

  task automatic rb(int p, logic [DW-1:0] exp, string req);
    @(negedge clk);
    cpu_addr = (p == 1) ? TXB : RXB; cpu_rd = 1'b1;
    #1 chk(req, cpu_rdata, exp, "readback");
    cpu_rd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int s0, s1;
    logic [DW-1:0] keep;
    idle(3);
    // R12 reset state
    chk("R12", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 8'hFF, "idle pins in reset");
    chk("R12", {sd_cke, busy, sd_dq_oe}, 6'b110000, "cke/busy/oe in reset");
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    chk("R12", {sd_cs_n, sd_cke, busy}, 6'b111100, "after reset");
    rb(0, 16'h0, "R12");

    // R8 CAS latency 2 on receive port, then basic commands
    issue(0, 4'hC, 13'h020, 16'h0, "R8");
    issue(0, 4'h3, 13'h123, 16'h0, "R5");
    issue(0, 4'h2, 13'h045, 16'hBEEF, "R11");
    issue(0, 4'h1, 13'h045, 16'h0, "R7");
    rb(0, exp_rd[0], "R7");
    issue(0, 4'h7, 13'h1F0, 16'h0, "R3");
    issue(0, 4'h6, 13'h0A0, 16'h1234, "R3");
    issue(0, 4'h5, 13'h0A0, 16'h0, "R7");
    rb(0, exp_rd[0], "R3");
    keep = exp_rd[0];

    // R8 default latency 3 on transmit port
    issue(1, 4'h1, 13'h0777, 16'h0, "R8");
    rb(1, exp_rd[1], "R8");
    rb(0, keep, "R10");
    @(negedge clk) cpu_addr = TXB;
    #1 chk("R7", cpu_rdata, 16'h0, "rdata without read strobe");

    issue(1, 4'h9, 13'h400, 16'h0, "R5");
    issue(1, 4'hA, 13'h000, 16'h0, "R5");

    // R4 no-op and reserved codes
    s0 = seen[0];
    issue(0, 4'h0, 13'h011, 16'h0, "R4");
    issue(0, 4'h4, 13'h011, 16'h0, "R4");
    issue(0, 4'h8, 13'h011, 16'h0, "R4");
    issue(0, 4'hB, 13'h011, 16'h0, "R4");
    issue(0, 4'hD, 13'h011, 16'h0, "R4");
    issue(0, 4'hF, 13'h011, 16'h0, "R4");
    idle(3);
    chk("R4", seen[0], s0, "commands from reserved codes");

    // R6 writes during busy are dropped
    issue(0, 4'hA, 13'h000, 16'h0, "R6", 1'b0);
    words(RXB, 4'h3, 13'h077, 16'h0);
    @(negedge clk);
    while (busy[0]) @(negedge clk);
    idle(4);
    chk("R6", seen[0], s0 + 1, "commands after writes during busy");
    issue(0, 4'h3, 13'h0AB, 16'h0, "R6");

    // R1 unmapped address
    s0 = seen[0]; s1 = seen[1];
    words(26'h2000002, 4'h3, 13'h055, 16'h0);
    words(26'h1000000, 4'h3, 13'h055, 16'h0);
    idle(4);
    chk("R1", seen[0] + seen[1], s0 + s1, "commands from unmapped address");
    chk("R1", busy, 2'b00, "busy after unmapped writes");

    // R10 write does not disturb readback
    issue(0, 4'h2, 13'h033, 16'hCAFE, "R10");
    rb(0, keep, "R10");

    // R9 self refresh on transmit port
    issue(1, 4'hE, 13'h000, 16'h0, "R9");
    chk("R9", sd_cke[1], 1'b0, "cke low after self refresh");
    issue(1, 4'h0, 13'h000, 16'h0, "R9");
    issue(1, 4'hB, 13'h000, 16'h0, "R9");
    chk("R9", sd_cke[1], 1'b0, "cke low after no-op");
    issue(1, 4'h3, 13'h155, 16'h0, "R9");
    chk("R9", sd_cke[1], 1'b1, "cke high after exit");

    // R8 back to latency 3 on receive port
    issue(0, 4'hC, 13'h030, 16'h0, "R8");
    issue(0, 4'h1, 13'h002, 16'h0, "R8");
    rb(0, exp_rd[0], "R8");
    issue(0, 4'hC, 13'h050, 16'h0, "R8");
    issue(0, 4'h5, 13'h003, 16'h0, "R8");
    rb(0, exp_rd[0], "R8");

    idle(5);
    chk("R2", q0.size() + q1.size(), 0, "expected commands never seen");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule